// File: doc/BRIEF.md
# Flash Read Checksum Calibration Engine

This block walks a region of serial flash through the first chip select, one 32-bit word at a time, and folds every word into a running 32-bit sum. Software programs a start address and a byte length, then arms a run. When the run ends the engine raises a completion flag and, if enabled, a level interrupt. The sum is then read back.

The block exists to tune read timing. The control word carries a trial clock-divisor code and a trial input-sampling-delay code. While its calibration bit is set, those two codes are driven out on override pins. The flash access engine uses them in place of the normal settings for the first chip select. Software first takes a reference sum at a slow, safe setting. It then repeats the run at faster divisors and shorter delays, and keeps the settings whose sum matches the reference.

Flash reads go out over a simple request/acknowledge port with one read in flight at a time. Data transfers toward memory and write direction runs are not performed.

Top module: `flash_cksum_engine`

## Requirements
- R1: After reset, every register reads zero, and `rdReq`, `irq`, `calActive`, `calDivisor` and `calDelay` are all 0.
- R2: The registers sit at these byte offsets: control at 0x80, start address at 0x84, byte length at 0x8C, sum (read-only) at 0x90, and status/interrupt control at 0x08. The start address and length read back exactly as written when the engine is idle.
- R3: A run starts on a control write that moves enable (bit 0) from 0 to 1 while write direction (bit 1) is 0. The start clears the sum. The engine then requests the words at the start address, start+4, start+8 and so on, in order. It holds `rdReq` and `rdAddr` steady until `rdAck` is seen.
- R4: The sum is the 32-bit wrap-around total of every `rdData` word accepted during the run.
- R5: The length is rounded down to a multiple of 4 bytes. Once the last word is accepted, the done flag (status bit 11) sets. A length below 4 issues no read, sets done, and leaves a sum of 0.
- R6: `irq` equals the done flag ANDed with the interrupt enable (status bit 3).
- R7: Writing zero to the status register clears done and the interrupt enable. A nonzero status write only loads bit 3 and leaves done unchanged.
- R8: While a run is in progress, a nonzero control write is ignored. The control register keeps its value and the run finishes with the correct sum.
- R9: Writing zero to the control register aborts a run. From the next cycle `rdReq` is 0 and the control register reads 0, and done does not set.
- R10: A control write with enable and write direction both set starts nothing: no read is issued and done does not set.
- R11: In the control word, bit 3 is calibration mode, bits [7:4] are the trial divisor code and bits [11:8] are the trial delay code. `calActive` follows bit 3, and `calDivisor` and `calDelay` follow their fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| rdReq | output | 1 | Flash word read request |
| rdAddr | output | 32 | Flash byte address of the requested word |
| rdAck | input | 1 | Read accepted, `rdData` valid |
| rdData | input | 32 | Little-endian flash word |
| calActive | output | 1 | Calibration override in force |
| calDivisor | output | 4 | Trial clock-divisor code |
| calDelay | output | 4 | Trial input-delay code |
| irq | output | 1 | Level completion interrupt |

## Verification
The sum is checked against a table of runs that vary the start address, the length and the control word. The lengths cover a long region whose total wraps past 32 bits, a one-word length with trailing bytes, an unaligned odd length, and a length under one word. Together these separate correct rounding and wrap-around from truncation and off-by-one word counts. The data pattern depends on the address, and acknowledge latency varies per word, so skipped words, repeated addresses and data taken before acknowledge all give a wrong sum. Directed runs cover abort, ignored writes while busy, write-direction arming and the clear rules of the status register.

// File: rtl/flash_cksum_pkg.sv
package flash_cksum_pkg;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h80;
  localparam logic [7:0] OFS_ADDR = 8'h84;
  localparam logic [7:0] OFS_LEN  = 8'h8C;
  localparam logic [7:0] OFS_SUM  = 8'h90;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_WDIR = 1;
  localparam int CTRL_SUM  = 2;
  localparam int CTRL_CAL  = 3;
  localparam int DIV_LSB   = 4;
  localparam int DLY_LSB   = 8;
  localparam int CODE_W    = 4;
  localparam int CTRL_W    = 12;

  localparam int STAT_IE   = 3;
  localparam int STAT_DONE = 11;

  typedef struct packed {
    logic start;
    logic take;
  } dpStrobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} engState_t;
endpackage

// File: rtl/cksum_datapath.sv
module cksum_datapath
  import flash_cksum_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              remZero,
  output logic [DATA_W-1:0] sumVal
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [CNT_W-1:0] wordsLeft;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr   <= '0;
      wordsLeft <= '0;
      sumVal    <= '0;
    end else if (strobe.start) begin
      curAddr   <= baseAddr;
      wordsLeft <= wordCount;
      sumVal    <= '0;
    end else if (strobe.take) begin
      curAddr   <= curAddr + STEP;
      wordsLeft <= wordsLeft - 1'b1;
      sumVal    <= sumVal + rdData;
    end
  end

  assign remZero = (wordsLeft == '0);

  AST_TAKE_NEEDS_WORDS: assert property (@(posedge clk) disable iff (rst)
    strobe.take |-> !remZero) else $error("take with no words left"); // R5
endmodule

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
  import flash_cksum_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rdAck,
  input  logic              remZero,
  output dpStrobe_t         strobe,
  output logic              rdReq,
  output logic              busy,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [ADDR_W-1:0] baseReg,
  output logic [LEN_W-1:0]  lenReg,
  output logic              done,
  output logic              irqEn
);
  engState_t state;

  logic selCtrl, ctrlZero, stopWr, acceptCtrl, startRun;

  assign busy       = (state == ST_RUN);
  assign selCtrl    = regWr && (regAddr == REG_AW'(OFS_CTRL));
  assign ctrlZero   = (regWrData == '0);
  assign stopWr     = selCtrl && ctrlZero;
  assign acceptCtrl = selCtrl && (!busy || ctrlZero);
  assign startRun   = acceptCtrl && !ctrlReg[CTRL_EN] &&
                      regWrData[CTRL_EN] && !regWrData[CTRL_WDIR];

  assign rdReq        = busy && !remZero;
  assign strobe.start = startRun;
  assign strobe.take  = rdReq && rdAck && !stopWr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ctrlReg <= '0;
      baseReg <= '0;
      lenReg  <= '0;
      done    <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (acceptCtrl) ctrlReg <= regWrData[CTRL_W-1:0];
      if (regWr && regAddr == REG_AW'(OFS_ADDR)) baseReg <= regWrData[ADDR_W-1:0];
      if (regWr && regAddr == REG_AW'(OFS_LEN))  lenReg  <= regWrData[LEN_W-1:0];
      if (regWr && regAddr == REG_AW'(OFS_STAT)) begin
        irqEn <= regWrData[STAT_IE];
        if (regWrData == '0) done <= 1'b0;
      end
      case (state)
        ST_IDLE: if (startRun) state <= ST_RUN;
        ST_RUN: begin
          if (stopWr) state <= ST_IDLE;
          else if (remZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && selCtrl && !ctrlZero) |=> $stable(ctrlReg)) else $error("busy write took effect"); // R8
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stopWr |=> (!rdReq && ctrlReg == '0)) else $error("stop did not halt"); // R9
  AST_LAST_WORD_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy && remZero && !stopWr) |=> (done && !busy)) else $error("no completion"); // R5
  AST_WDIR_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && selCtrl && regWrData[CTRL_WDIR]) |=> !busy) else $error("write dir started"); // R10
endmodule

// File: rtl/flash_cksum_engine.sv
module flash_cksum_engine
  import flash_cksum_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              calActive,
  output logic [CODE_W-1:0] calDivisor,
  output logic [CODE_W-1:0] calDelay,
  output logic              irq
);
  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
  localparam int CNT_W      = LEN_W - BYTE_SHIFT;

  dpStrobe_t         strobe;
  logic              busy, remZero, done, irqEn;
  logic [CTRL_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] baseReg;
  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] sumVal;

  cksum_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .REG_AW(REG_AW)) uCtrl (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .rdAck(rdAck), .remZero(remZero), .strobe(strobe), .rdReq(rdReq), .busy(busy),
    .ctrlReg(ctrlReg), .baseReg(baseReg), .lenReg(lenReg), .done(done), .irqEn(irqEn)
  );

  cksum_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .baseAddr(baseReg),
    .wordCount(lenReg[LEN_W-1:BYTE_SHIFT]), .rdData(rdData),
    .curAddr(rdAddr), .remZero(remZero), .sumVal(sumVal)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_AW'(OFS_CTRL): regRdData = DATA_W'(ctrlReg);
      REG_AW'(OFS_ADDR): regRdData = DATA_W'(baseReg);
      REG_AW'(OFS_LEN):  regRdData = DATA_W'(lenReg);
      REG_AW'(OFS_SUM):  regRdData = sumVal;
      REG_AW'(OFS_STAT): begin
        regRdData[STAT_DONE] = done;
        regRdData[STAT_IE]   = irqEn;
      end
      default: regRdData = '0;
    endcase
  end

  assign calActive  = ctrlReg[CTRL_CAL];
  assign calDivisor = ctrlReg[DIV_LSB +: CODE_W];
  assign calDelay   = ctrlReg[DLY_LSB +: CODE_W];
  assign irq        = done && irqEn;

  logic stopping;
  assign stopping = regWr && (regAddr == REG_AW'(OFS_CTRL)) && (regWrData == '0);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdReq && !rdAck && !stopping) |=> (rdReq && $stable(rdAddr))) else $error("request dropped"); // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> regAddr == regAddr && irqEn) else $error("irq without enable"); // R6
endmodule

// File: tb/sim_flash_cksum_engine.sv
module sim_flash_cksum_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [31:0] rdData = '0;
  logic        calActive;
  logic [3:0]  calDivisor, calDelay;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;
  int lat = 0;
  int waitCnt = 0;
  int readCount = 0;
  int addrErr = 0;
  logic [31:0] expBase = '0;
  logic [31:0] seed = '0;

  always #5 clk = ~clk;

  flash_cksum_engine u0 (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .calActive(calActive), .calDivisor(calDivisor), .calDelay(calDelay), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a, input logic [31:0] s);
    return (a * 32'h9E37_79B1) ^ s;
  endfunction

  // flash responder: variable latency, checks address order
  always @(negedge clk) begin
    if (rdAck) begin
      rdAck = 1'b0;
    end else if (rdReq) begin
      if (waitCnt <= 0) begin
        if (rdAddr !== expBase + 32'(readCount * 4)) addrErr++;
        rdData = pat(rdAddr, seed);
        rdAck = 1'b1;
        readCount++;
        waitCnt = (lat + readCount) % 3;
      end else waitCnt--;
    end else waitCnt = lat;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      regRead(8'h08, s);
      if (s[11]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] expSum(input logic [31:0] b, input logic [31:0] len,
                                         input logic [31:0] s);
    logic [31:0] acc = '0;
    for (int k = 0; k < int'(len >> 2); k++) acc += pat(b + 32'(k * 4), s);
    return acc;
  endfunction

  localparam int NV = 5;
  localparam logic [31:0] V_BASE [NV] = '{32'h0001_0000, 32'h0000_0100, 32'h2000_0004, 32'h0000_0040, 32'h0000_0800};
  localparam logic [31:0] V_LEN  [NV] = '{32'h0000_0200, 32'h0000_0007, 32'h0000_0013, 32'h0000_0003, 32'h0000_0040};
  localparam logic [31:0] V_CTRL [NV] = '{32'h0000_0BDD, 32'h0000_0005, 32'h0000_0F1D, 32'h0000_0005, 32'h0000_03CD};

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    regRead(8'h80, r); chk("R1 ctrl", r, 0);
    regRead(8'h84, r); chk("R1 addr", r, 0);
    regRead(8'h8C, r); chk("R1 len", r, 0);
    regRead(8'h90, r); chk("R1 sum", r, 0);
    regRead(8'h08, r); chk("R1 stat", r, 0);
    chk("R1 outs", {27'd0, rdReq, irq, calActive, |calDivisor, |calDelay}, 0);

    // R2 register readback
    regWrite(8'h84, 32'hDEAD_BEE4); regWrite(8'h8C, 32'h0000_1235);
    regRead(8'h84, r); chk("R2 addr", r, 32'hDEAD_BEE4);
    regRead(8'h8C, r); chk("R2 len", r, 32'h0000_1235);

    // vector table: R3 R4 R5 R6 R11
    for (int i = 0; i < NV; i++) begin
      seed = 32'h1357_0000 + 32'(i * 32'h1111);
      lat = i;
      expBase = V_BASE[i];
      readCount = 0; addrErr = 0;
      regWrite(8'h08, 32'h8);
      regWrite(8'h84, V_BASE[i]);
      regWrite(8'h8C, V_LEN[i]);
      regWrite(8'h80, V_CTRL[i]);
      waitDone(ok);
      chk("R5 done", 32'(ok), 1);
      regRead(8'h90, r); chk("R4 sum", r, expSum(V_BASE[i], V_LEN[i], seed));
      chk("R3 reads", 32'(readCount), V_LEN[i] >> 2);
      chk("R3 addr order", 32'(addrErr), 0);
      chk("R6 irq on", 32'(irq), 1);
      chk("R11 cal", {calActive, calDivisor, calDelay},
          {V_CTRL[i][3], V_CTRL[i][7:4], V_CTRL[i][11:8]});
      regWrite(8'h08, 32'h0);
      regRead(8'h08, r); chk("R7 clear", r, 0);
      chk("R6 irq off", 32'(irq), 0);
      regWrite(8'h80, 32'h0);
      chk("R11 cal off", 32'(calActive), 0);
    end

    // R6 R7: enable off then nonzero status write keeps done
    seed = 32'hA5A5_0001; expBase = 32'h300; readCount = 0; addrErr = 0; lat = 1;
    regWrite(8'h84, 32'h300); regWrite(8'h8C, 32'h10);
    regWrite(8'h80, 32'h5);
    waitDone(ok);
    chk("R6 irq masked", 32'(irq), 0);
    regWrite(8'h08, 32'h8);
    regRead(8'h08, r); chk("R7 nonzero keeps done", r, 32'h808);
    chk("R6 irq enabled", 32'(irq), 1);
    regWrite(8'h08, 32'h0); regWrite(8'h80, 32'h0);

    // R8 nonzero control write while busy ignored
    seed = 32'h0BAD_F00D; expBase = 32'h1000; readCount = 0; addrErr = 0; lat = 2;
    regWrite(8'h84, 32'h1000); regWrite(8'h8C, 32'h80);
    regWrite(8'h80, 32'h8F5);
    repeat (5) @(negedge clk);
    regWrite(8'h80, 32'h3);
    regRead(8'h80, r); chk("R8 ctrl kept", r, 32'h8F5);
    waitDone(ok);
    regRead(8'h90, r); chk("R8 sum", r, expSum(32'h1000, 32'h80, seed));
    regWrite(8'h08, 32'h0); regWrite(8'h80, 32'h0);

    // R9 abort
    expBase = 32'h2000; readCount = 0; addrErr = 0;
    regWrite(8'h84, 32'h2000); regWrite(8'h8C, 32'h400);
    regWrite(8'h80, 32'h5);
    repeat (6) @(negedge clk);
    regWrite(8'h80, 32'h0);
    chk("R9 req low", 32'(rdReq), 0);
    regRead(8'h80, r); chk("R9 ctrl zero", r, 0);
    repeat (20) @(negedge clk);
    regRead(8'h08, r); chk("R9 no done", r, 0);
    chk("R9 req stays low", 32'(rdReq), 0);

    // R10 write direction arms nothing
    readCount = 0;
    regWrite(8'h8C, 32'h10);
    regWrite(8'h80, 32'h3);
    repeat (20) @(negedge clk);
    chk("R10 no reads", 32'(readCount), 0);
    regRead(8'h08, r); chk("R10 no done", r, 0);
    regWrite(8'h80, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule